// File: doc/BRIEF.md
# Clock Frequency and Glitch Monitor

This block watches one clock produced by a PLL and judges its health against a trusted, free-running reference clock. Edges of the monitored clock are carried into the reference domain through a small Gray-coded counter. There they are added up over a long measurement window, to check average frequency, and over a short sub-window, to catch bursts of short periods. A separate idle counter spots a clock that has stopped. Four fault kinds are kept: overrun, underrun, glitch and stop. Each fault sets a flag that stays set until software reads the status. A read clears the flags.

Each monitored clock gets its own instance. The nominal monitored frequency, the reference frequency and the tolerance are parameters, so the same RTL serves a 100 MHz, a 200 MHz or a 156.25 MHz clock. A read returns the health of that one clock. Gathering several instances under one read is done by whoever instantiates them. The first measurement window after reset is thrown away, so lock-up transients never show as faults.

Top module: `clock_health_monitor`

## Requirements
- R1: `statusOk` is 1 exactly when all four bits of `faultFlags` are 0. Bit 0 is overrun, bit 1 is underrun, bit 2 is glitch and bit 3 is stop.
- R2: Overrun is set when a monitored-edge count over a window of 2^WIN_LOG2 reference cycles exceeds the nominal count plus the tolerance count.
- R3: Underrun is set when that window count falls below the nominal count minus the tolerance count.
- R4: Glitch is set when a count over any aligned sub-window of 2^SUB_LOG2 reference cycles departs from its nominal value by more than twice the window tolerance count.
- R5: Stop is set once STOP_CYCLES consecutive reference cycles pass with no monitored edge arriving.
- R6: Once set, a fault flag stays set until a read strobe, even after the fault condition has ended.
- R7: A one-cycle `rdStrobe` clears the flags on the next reference edge. A fault that is detected in the read cycle itself is kept for the next read.
- R8: No fault is raised during the first measurement window after reset, even if the monitored clock is absent or off-frequency then.
- R9: During and right after reset, `faultFlags` is 0 and `statusOk` is 1.
- R10: With nominal frequencies of 100 MHz, 200 MHz and 156.25 MHz, set by parameter, a clock running at its nominal rate reads as healthy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Trusted free-running reference clock; all outputs are in this domain |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| monClk | input | 1 | Clock under observation |
| rdStrobe | input | 1 | One-cycle read pulse; clears the sticky flags after this cycle |
| statusOk | output | 1 | High when no fault has been seen since the last read |
| faultFlags | output | 4 | Sticky faults: [0] overrun, [1] underrun, [2] glitch, [3] stop |

## Verification
The 100 MHz instance is driven in turn at its nominal period and at a period about 10 % short. It is then driven about 10 % long, given a burst at double rate, and halted. Each pattern should raise only the fault class it targets among overrun, underrun and stop. The glitch burst is also checked for not being taken as a stop. Reads are placed both after a fault has ended and while a stop is still present. This separates sticky holding from clear-on-read, and shows that a fault live in the read cycle is carried over. A late clock start inside the first window checks the warm-up discard. Two more instances at 200 MHz and 156.25 MHz show that the parameter-derived expected counts stay healthy at nominal rate.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  localparam int unsigned FAULT_NUM = 4;

  // Bit positions inside the fault vector (decoded by software)
  typedef enum int unsigned {
    F_OVER   = 0,
    F_UNDER  = 1,
    F_GLITCH = 2,
    F_STOP   = 3
  } fault_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic winEnd;   // last reference cycle of a long window
    logic subEnd;   // last reference cycle of a sub-window
    logic armed;    // warm-up window has passed
  } meas_ctl_t;

  // Rounded edge count expected over 2^log2Len reference cycles
  function automatic longint unsigned expected_count(
    input longint unsigned monKhz,
    input longint unsigned refKhz,
    input int unsigned     log2Len
  );
    return ((monKhz << log2Len) + refKhz / 2) / refKhz;
  endfunction

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int unsigned GRAY_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              monClk,
  input  logic              refClk,
  input  logic              rstN,
  output logic [GRAY_W-1:0] edgeDelta
);

  // Monitored domain: free-running binary counter with a Gray copy
  logic [GRAY_W-1:0] binCnt, binNext, grayCnt;

  assign binNext = binCnt + 1'b1;

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      binCnt  <= '0;
      grayCnt <= '0;
    end else begin
      binCnt  <= binNext;
      grayCnt <= binNext ^ (binNext >> 1);
    end
  end

  // Reference domain: synchroniser chain
  logic [GRAY_W-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= grayCnt;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  function automatic logic [GRAY_W-1:0] gray_to_bin(input logic [GRAY_W-1:0] g);
    logic [GRAY_W-1:0] b;
    b[GRAY_W-1] = g[GRAY_W-1];
    for (int i = int'(GRAY_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [GRAY_W-1:0] curBin, prevBin;

  assign curBin = gray_to_bin(syncQ[SYNC_STAGES-1]);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) prevBin <= '0;
    else       prevBin <= curBin;
  end

  // Edges seen in the last reference cycle (modulo 2^GRAY_W)
  assign edgeDelta = curBin - prevBin;

endmodule

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int unsigned GRAY_W      = 4,
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SUB_W       = 12,
  parameter int unsigned WIN_HI      = 100,
  parameter int unsigned WIN_LO      = 90,
  parameter int unsigned SUB_EXP     = 10,
  parameter int unsigned SUB_TOL     = 4,
  parameter int unsigned STOP_CYCLES = 64
) (
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic [GRAY_W-1:0]    edgeDelta,
  input  meas_ctl_t            ctl,
  output logic [FAULT_NUM-1:0] faultEvt
);

  localparam int unsigned IDLE_W = $clog2(STOP_CYCLES + 1);

  logic [CNT_W-1:0] winAcc, winSum;
  logic [SUB_W-1:0] subAcc, subSum, subDiff;

  assign winSum = winAcc + {{(CNT_W-GRAY_W){1'b0}}, edgeDelta};
  assign subSum = subAcc + {{(SUB_W-GRAY_W){1'b0}}, edgeDelta};

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winAcc <= '0;
      subAcc <= '0;
    end else begin
      winAcc <= ctl.winEnd ? '0 : winSum;
      subAcc <= ctl.subEnd ? '0 : subSum;
    end
  end

  assign subDiff = (subSum > SUB_W'(SUB_EXP)) ? (subSum - SUB_W'(SUB_EXP))
                                              : (SUB_W'(SUB_EXP) - subSum);

  always_comb begin
    faultEvt = '0;
    faultEvt[F_OVER]   = ctl.armed && ctl.winEnd && (winSum > CNT_W'(WIN_HI));
    faultEvt[F_UNDER]  = ctl.armed && ctl.winEnd && (winSum < CNT_W'(WIN_LO));
    faultEvt[F_GLITCH] = ctl.armed && ctl.subEnd && (subDiff > SUB_W'(SUB_TOL));
    faultEvt[F_STOP]   = ctl.armed && stopSeen;
  end

  logic stopSeen;

  generate
    if (STOP_CYCLES > 0) begin : g_stop
      logic [IDLE_W-1:0] idleCnt;
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN)                               idleCnt <= '0;
        else if (edgeDelta != '0)                idleCnt <= '0;
        else if (idleCnt != IDLE_W'(STOP_CYCLES)) idleCnt <= idleCnt + 1'b1;
      end
      assign stopSeen = (idleCnt == IDLE_W'(STOP_CYCLES));
    end else begin : g_nostop
      assign stopSeen = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/clkmon_control.sv
module clkmon_control
  import clkmon_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 16,
  parameter int unsigned SUB_LOG2 = 8
) (
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic                 rdStrobe,
  input  logic [FAULT_NUM-1:0] faultEvt,
  output meas_ctl_t            ctl,
  output logic [FAULT_NUM-1:0] stickyFlags
);

  logic [WIN_LOG2-1:0] refCnt;
  logic                armedQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      armedQ <= 1'b0;
    end else begin
      refCnt <= refCnt + 1'b1;
      if (&refCnt) armedQ <= 1'b1;
    end
  end

  assign ctl.winEnd = &refCnt;
  assign ctl.subEnd = &refCnt[SUB_LOG2-1:0];
  assign ctl.armed  = armedQ;

  // Sticky flags: a read clears, but faults of the read cycle survive
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)         stickyFlags <= '0;
    else if (rdStrobe) stickyFlags <= faultEvt;
    else               stickyFlags <= stickyFlags | faultEvt;
  end

endmodule

// File: rtl/clock_health_monitor.sv
module clock_health_monitor
  import clkmon_pkg::*;
#(
  parameter int unsigned REF_KHZ     = 125000,
  parameter int unsigned MON_KHZ     = 100000,
  parameter int unsigned TOL_PPM     = 500,
  parameter int unsigned WIN_LOG2    = 16,
  parameter int unsigned SUB_LOG2    = 8,
  parameter int unsigned STOP_CYCLES = 64,
  parameter int unsigned GRAY_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic                 monClk,
  input  logic                 rdStrobe,
  output logic                 statusOk,
  output logic [FAULT_NUM-1:0] faultFlags
);

  localparam longint unsigned WIN_EXP_L = expected_count(MON_KHZ, REF_KHZ, WIN_LOG2);
  localparam longint unsigned SUB_EXP_L = expected_count(MON_KHZ, REF_KHZ, SUB_LOG2);
  localparam longint unsigned WIN_TOL_L = (WIN_EXP_L * TOL_PPM) / 1000000 + 1;
  localparam int unsigned WIN_EXP = int'(WIN_EXP_L);
  localparam int unsigned WIN_TOL = int'(WIN_TOL_L);
  localparam int unsigned WIN_HI  = WIN_EXP + WIN_TOL;
  localparam int unsigned WIN_LO  = (WIN_EXP > WIN_TOL) ? WIN_EXP - WIN_TOL : 0;
  localparam int unsigned SUB_EXP = int'(SUB_EXP_L);
  localparam int unsigned SUB_TOL = 2 * WIN_TOL;
  localparam int unsigned CNT_W   = WIN_LOG2 + GRAY_W;
  localparam int unsigned SUB_W   = SUB_LOG2 + GRAY_W;

  logic [GRAY_W-1:0]    edgeDelta;
  meas_ctl_t            ctlBus;
  logic [FAULT_NUM-1:0] faultEvt;
  logic [FAULT_NUM-1:0] stickyFlags;
  logic                 measArmed;

  clkmon_edge_sync #(
    .GRAY_W      (GRAY_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .monClk    (monClk),
    .refClk    (refClk),
    .rstN      (rstN),
    .edgeDelta (edgeDelta)
  );

  clkmon_datapath #(
    .GRAY_W      (GRAY_W),
    .CNT_W       (CNT_W),
    .SUB_W       (SUB_W),
    .WIN_HI      (WIN_HI),
    .WIN_LO      (WIN_LO),
    .SUB_EXP     (SUB_EXP),
    .SUB_TOL     (SUB_TOL),
    .STOP_CYCLES (STOP_CYCLES)
  ) u_dp (
    .refClk    (refClk),
    .rstN      (rstN),
    .edgeDelta (edgeDelta),
    .ctl       (ctlBus),
    .faultEvt  (faultEvt)
  );

  clkmon_control #(
    .WIN_LOG2 (WIN_LOG2),
    .SUB_LOG2 (SUB_LOG2)
  ) u_ctrl (
    .refClk      (refClk),
    .rstN        (rstN),
    .rdStrobe    (rdStrobe),
    .faultEvt    (faultEvt),
    .ctl         (ctlBus),
    .stickyFlags (stickyFlags)
  );

  assign measArmed  = ctlBus.armed;
  assign faultFlags = stickyFlags;
  assign statusOk   = ~|stickyFlags;

endmodule

// File: rtl/clock_health_monitor_chk.sv
module clock_health_monitor_chk (
  input logic       refClk,
  input logic       rstN,
  input logic       rdStrobe,
  input logic       statusOk,
  input logic [3:0] faultFlags,
  input logic [3:0] faultEvt,
  input logic       armed
);

  // R7: after a read only the faults of the read cycle remain
  p_read_clear_r7: assert property (@(posedge refClk) disable iff (!rstN)
    rdStrobe |=> (faultFlags == $past(faultEvt)));

  // R6: without a read no flag can drop
  p_sticky_hold_r6: assert property (@(posedge refClk) disable iff (!rstN)
    !rdStrobe |=> ((faultFlags & $past(faultFlags)) == $past(faultFlags)));

  // R1: a detected fault makes the status bad on the next cycle
  p_fault_shows_r1: assert property (@(posedge refClk) disable iff (!rstN)
    (|faultEvt) |=> !statusOk);

  // R8: nothing is flagged before the warm-up window has passed
  p_warmup_quiet_r8: assert property (@(posedge refClk) disable iff (!rstN)
    !armed |-> (faultFlags == 4'b0000));

  // R8: once armed the monitor stays armed
  p_armed_stays_r8: assert property (@(posedge refClk) disable iff (!rstN)
    armed |=> armed);

endmodule

bind clock_health_monitor clock_health_monitor_chk u_chk (
  .refClk     (refClk),
  .rstN       (rstN),
  .rdStrobe   (rdStrobe),
  .statusOk   (statusOk),
  .faultFlags (faultFlags),
  .faultEvt   (faultEvt),
  .armed      (measArmed)
);

// File: tb/clock_health_monitor_tb.sv
module clock_health_monitor_tb;

  // Time unit taken as 100 ps: reference 250 MHz = period 40
  localparam int unsigned WIN_CYC = 1024;

  logic refClk = 0;
  logic rstN   = 0;
  logic rdStrobe = 0;
  logic mon100 = 0, mon200 = 0, mon156 = 0;
  bit   run100 = 0;
  int   half100 = 50;

  logic       ok100, ok200, ok156;
  logic [3:0] flags100, flags200, flags156;

  int checks = 0;
  int errors = 0;

  always #20 refClk = ~refClk;
  always #25 mon200 = ~mon200;
  always #32 mon156 = ~mon156;

  initial begin
    forever begin
      if (run100) begin
        #(half100) mon100 = ~mon100;
      end else begin
        #10;
      end
    end
  end

  clock_health_monitor #(
    .REF_KHZ(250000), .MON_KHZ(100000), .TOL_PPM(20000),
    .WIN_LOG2(10), .SUB_LOG2(6), .STOP_CYCLES(64)
  ) u_dut (
    .refClk(refClk), .rstN(rstN), .monClk(mon100), .rdStrobe(rdStrobe),
    .statusOk(ok100), .faultFlags(flags100)
  );

  clock_health_monitor #(
    .REF_KHZ(250000), .MON_KHZ(200000), .TOL_PPM(20000),
    .WIN_LOG2(10), .SUB_LOG2(6), .STOP_CYCLES(64)
  ) u_dut200 (
    .refClk(refClk), .rstN(rstN), .monClk(mon200), .rdStrobe(rdStrobe),
    .statusOk(ok200), .faultFlags(flags200)
  );

  clock_health_monitor #(
    .REF_KHZ(250000), .MON_KHZ(156250), .TOL_PPM(20000),
    .WIN_LOG2(10), .SUB_LOG2(6), .STOP_CYCLES(64)
  ) u_dut156 (
    .refClk(refClk), .rstN(rstN), .monClk(mon156), .rdStrobe(rdStrobe),
    .statusOk(ok156), .faultFlags(flags156)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic do_read();
    @(negedge refClk) rdStrobe = 1;
    @(negedge refClk) rdStrobe = 0;
  endtask

  // R9 and R8: reset state, then a late clock start inside the first window
  task automatic t_reset_warmup();
    rstN = 0;
    wait_cyc(5);
    check("R9 flags in reset", {28'd0, flags100}, 32'h0);
    check("R9 statusOk in reset", {31'd0, ok100}, 32'h1);
    rstN = 1;
    wait_cyc(2);
    check("R9 flags after reset", {28'd0, flags100}, 32'h0);
    wait_cyc(300);
    run100 = 1;
    wait_cyc(3 * WIN_CYC);
    check("R8 no fault from first window", {28'd0, flags100}, 32'h0);
    check("R8 statusOk after warm-up", {31'd0, ok100}, 32'h1);
  endtask

  // R10: three nominal frequencies read healthy
  task automatic t_nominal();
    check("R10 100 MHz healthy", {31'd0, ok100}, 32'h1);
    check("R10 200 MHz healthy", {28'd0, flags200}, 32'h0);
    check("R10 156.25 MHz healthy", {28'd0, flags156}, 32'h0);
  endtask

  // R2, R1, R6, R7: overrun, stays after it ends, cleared by read
  task automatic t_overrun();
    half100 = 45;
    wait_cyc(3 * WIN_CYC);
    check("R2 overrun bit", {31'd0, flags100[0]}, 32'h1);
    check("R2 no underrun on fast clock", {31'd0, flags100[1]}, 32'h0);
    check("R1 statusOk low on fault", {31'd0, ok100}, 32'h0);
    half100 = 50;
    wait_cyc(3 * WIN_CYC);
    check("R6 overrun still held", {31'd0, flags100[0]}, 32'h1);
    do_read();
    wait_cyc(2);
    check("R7 flags cleared by read", {28'd0, flags100}, 32'h0);
    check("R1 statusOk back high", {31'd0, ok100}, 32'h1);
  endtask

  // R3: underrun only
  task automatic t_underrun();
    half100 = 55;
    wait_cyc(3 * WIN_CYC);
    check("R3 underrun bit", {31'd0, flags100[1]}, 32'h1);
    check("R3 no overrun on slow clock", {31'd0, flags100[0]}, 32'h0);
    check("R3 no stop on slow clock", {31'd0, flags100[3]}, 32'h0);
    half100 = 50;
    wait_cyc(2 * WIN_CYC);
    do_read();
    wait_cyc(2);
    check("R7 clean after underrun read", {28'd0, flags100}, 32'h0);
  endtask

  // R4: double-rate burst covering a full sub-window
  task automatic t_glitch();
    half100 = 25;
    wait_cyc(128);
    half100 = 50;
    wait_cyc(100);
    check("R4 glitch bit", {31'd0, flags100[2]}, 32'h1);
    check("R4 burst is not a stop", {31'd0, flags100[3]}, 32'h0);
    wait_cyc(2 * WIN_CYC);
    do_read();
    wait_cyc(2);
    check("R7 clean after glitch read", {28'd0, flags100}, 32'h0);
  endtask

  // R5 and R7: stop, then a read while the stop is still present
  task automatic t_stop();
    run100 = 0;
    wait_cyc(200);
    check("R5 stop bit", {31'd0, flags100[3]}, 32'h1);
    do_read();
    wait_cyc(1);
    check("R7 live stop survives read", {31'd0, flags100[3]}, 32'h1);
    run100 = 1;
    wait_cyc(2 * WIN_CYC);
    do_read();
    wait_cyc(2);
    check("R7 clean after restart", {28'd0, flags100}, 32'h0);
    do_read();
    wait_cyc(2);
    check("R1 read with no fault keeps good", {31'd0, ok100}, 32'h1);
  endtask

  initial begin
    t_reset_warmup();
    t_nominal();
    t_overrun();
    t_underrun();
    t_glitch();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge refClk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule